// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Runtime Write Policy

This block is a direct-mapped data cache placed between a processor's load/store port and a word-wide main-memory port. A byte address is cut into three fields: the tag in the upper bits, a line index in the middle and a word offset at the bottom. Each memory block has exactly one home line. A lookup reads the line chosen by the index and compares the tag stored there with the address tag. A read hit returns the word from the line. A read miss first copies the dirty victim back to memory if needed, then fetches the whole block word by word, and only then returns the requested word.

Two configuration inputs are sampled while the cache is in operation. One bypasses the cache entirely. The other switches the write policy from write-back, the default, to write-through with no allocation on a write miss. Two command pulses empty the cache. The first drops every line at once and writes nothing back. The second walks all lines, copies each dirty one to memory, and then drops them all. The processor sees a single busy signal that stays high while any lookup, fill, write-back or walk is in progress.

Top module: `dmc_top`

## Requirements
- R1: After reset `cpuBusy`, `cpuDone` and `memReq` are low and no line is valid, so the first read of any address misses.
- R2: A read hit completes with `cpuDone` two clock edges after the request is accepted. It carries the line's word and causes no memory transaction.
- R3: A read miss on a clean line issues LINE_WORDS memory reads in ascending order from the block base, where word k is at base + 4k. It then returns the requested word. `memAddr` stays stable while a transaction waits for `memAck`.
- R4: In write-back mode (`cfgWriteThru`=0) a write hit changes only the cached word, causes no memory transaction, and marks the line dirty.
- R5: A miss whose victim line is dirty first writes the victim's LINE_WORDS words to its old block address, then fills the line. A clean victim is not written.
- R6: In write-through mode (`cfgWriteThru`=1) every write issues exactly one memory write of that word. A write hit also updates the cached word.
- R7: In write-through mode a write miss does not allocate, so a later read of that address misses.
- R8: With `cfgBypass`=1 every access is one single-word memory transaction, and no line is allocated or modified.
- R9: `cmdInvalidate` clears every line without any memory write, and dirty data is discarded.
- R10: `cmdFlush` writes every dirty line back, skips clean lines, and then leaves all lines invalid.
- R11: While idle, `cmdFlush` has priority over `cmdInvalidate`, which has priority over `cpuReq`. Memory is only requested while `cpuBusy` is high.
- R12: Address bits split as tag | index | word offset | byte offset (2 bits). Two blocks with equal index and different tags evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBypass | input | 1 | 1: every access bypasses the cache |
| cfgWriteThru | input | 1 | 1: write-through, no write allocate; 0: write-back |
| cmdFlush | input | 1 | Pulse: write back dirty lines, then invalidate all |
| cmdInvalidate | input | 1 | Pulse: invalidate all lines, no write-back |
| cpuReq | input | 1 | Access request, accepted when `cpuBusy` is low |
| cpuWe | input | 1 | 1: write access |
| cpuAddr | input | ADDR_W | Byte address |
| cpuWdata | input | DATA_W | Write data |
| cpuRdata | output | DATA_W | Read data, valid with `cpuDone` |
| cpuBusy | output | 1 | Stall: an operation is in progress |
| cpuDone | output | 1 | One-cycle completion pulse |
| memReq | output | 1 | Memory transaction request, held until `memAck` |
| memWe | output | 1 | 1: memory write |
| memAddr | output | ADDR_W | Word-aligned memory byte address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data, valid with `memAck` |
| memAck | input | 1 | Memory transaction complete |

## Verification
Accesses are chained so that each one lands in a known line state: invalid, clean with a matching tag, dirty with a matching tag, and occupied by a conflicting tag. The bench logs memory traffic, and that log separates a hit (no traffic) from a clean fill (reads only) and from a dirty eviction (writes to the old block before the reads). The same addresses are then reused under write-through and under bypass. Stale cached data seen after a bypassed write, and memory contents seen after invalidate versus flush, separate the policies from one another. A combined flush-and-invalidate pulse on a dirty line shows which command wins.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_WB,
    S_FILL,
    S_SINGLE,
    S_FSCAN,
    S_FWB
  } dmc_state_e;

  typedef enum logic [1:0] {
    SEL_REQ,
    SEL_FILL,
    SEL_WB
  } addr_sel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      capture;
    logic      cpuWrite;
    logic      markDirty;
    logic      fillWord;
    logic      setTag;
    logic      clrAll;
    logic      rspHit;
    logic      rspMem;
    logic      useScan;
    addr_sel_e addrSel;
  } dmc_strobe_t;

endpackage

// File: rtl/dmc_datapath.sv
module dmc_datapath
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 4,
  parameter int LINE_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dmc_strobe_t                   st,
  input  logic [$clog2(LINE_WORDS)-1:0] wordCnt,
  input  logic [IDX_W-1:0]              scanIdx,
  input  logic                          cpuWe,
  input  logic [ADDR_W-1:0]             cpuAddr,
  input  logic [DATA_W-1:0]             cpuWdata,
  input  logic [DATA_W-1:0]             memRdata,
  output logic                          hit,
  output logic                          lineValid,
  output logic                          lineDirty,
  output logic                          reqWe,
  output logic [DATA_W-1:0]             cpuRdata,
  output logic [ADDR_W-1:0]             memAddr,
  output logic [DATA_W-1:0]             memWdata
);
  localparam int BOFF_W = $clog2(DATA_W / 8);
  localparam int WOFF_W = $clog2(LINE_WORDS);
  localparam int LINES  = 1 << IDX_W;
  localparam int TAG_W  = ADDR_W - IDX_W - WOFF_W - BOFF_W;
  localparam int WA_W   = ADDR_W - BOFF_W;

  logic [WA_W-1:0]   reqWord;
  logic [DATA_W-1:0] reqWdata;
  logic [TAG_W-1:0]  reqTag;
  logic [IDX_W-1:0]  reqIdx;
  logic [WOFF_W-1:0] reqOff;
  logic [IDX_W-1:0]  idx;
  logic [BOFF_W-1:0] unusedByteBits;

  logic [LINES-1:0]  validQ;
  logic [LINES-1:0]  dirtyQ;
  logic [TAG_W-1:0]  tagQ  [LINES];
  logic [DATA_W-1:0] dataQ [LINES][LINE_WORDS];

  assign unusedByteBits = cpuAddr[BOFF_W-1:0];

  // Field split: tag | index | word offset | byte offset
  assign reqTag = reqWord[WA_W-1 -: TAG_W];
  assign reqIdx = reqWord[WOFF_W +: IDX_W];
  assign reqOff = reqWord[WOFF_W-1:0];
  assign idx    = st.useScan ? scanIdx : reqIdx;

  assign lineValid = validQ[idx];
  assign lineDirty = dirtyQ[idx];
  assign hit       = validQ[idx] && (tagQ[idx] == reqTag);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqWord  <= '0;
      reqWdata <= '0;
      reqWe    <= 1'b0;
    end else if (st.capture) begin
      reqWord  <= cpuAddr[ADDR_W-1:BOFF_W];
      reqWdata <= cpuWdata;
      reqWe    <= cpuWe;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      dirtyQ <= '0;
    end else if (st.clrAll) begin
      validQ <= '0;
      dirtyQ <= '0;
    end else begin
      if (st.setTag) begin
        validQ[idx] <= 1'b1;
        dirtyQ[idx] <= 1'b0;
      end
      if (st.cpuWrite && st.markDirty) dirtyQ[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st.setTag) tagQ[idx] <= reqTag;
    if (st.fillWord) dataQ[idx][wordCnt] <= memRdata;
    else if (st.cpuWrite) dataQ[idx][reqOff] <= reqWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cpuRdata <= '0;
    else if (st.rspHit) cpuRdata <= dataQ[idx][reqOff];
    else if (st.rspMem) cpuRdata <= memRdata;
  end

  always_comb begin
    unique case (st.addrSel)
      SEL_FILL: memAddr = {reqTag, reqIdx, wordCnt, {BOFF_W{1'b0}}};
      SEL_WB:   memAddr = {tagQ[idx], idx, wordCnt, {BOFF_W{1'b0}}};
      default:  memAddr = {reqWord, {BOFF_W{1'b0}}};
    endcase
    memWdata = (st.addrSel == SEL_WB) ? dataQ[idx][wordCnt] : reqWdata;
  end

  // R4: a dirty line is always a valid line
  p_dirty_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    lineDirty |-> lineValid);

  // R3: after the last fill word the held request hits
  p_fill_hits_r3: assert property (@(posedge clk) disable iff (!rstN)
    st.setTag |=> hit);

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int LINE_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgBypass,
  input  logic                          cfgWriteThru,
  input  logic                          cmdFlush,
  input  logic                          cmdInvalidate,
  input  logic                          cpuReq,
  input  logic                          hit,
  input  logic                          lineValid,
  input  logic                          lineDirty,
  input  logic                          reqWe,
  input  logic                          memAck,
  output dmc_strobe_t                   st,
  output logic [$clog2(LINE_WORDS)-1:0] wordCnt,
  output logic [IDX_W-1:0]              scanIdx,
  output logic                          memReq,
  output logic                          memWe,
  output logic                          cpuBusy,
  output logic                          cpuDone
);
  localparam int WOFF_W = $clog2(LINE_WORDS);

  dmc_state_e        stQ, nxt;
  logic [WOFF_W-1:0] cntNext;
  logic [IDX_W-1:0]  scanNext;
  logic              doneNext;
  logic              lastWord, lastLine;

  assign lastWord = &wordCnt;
  assign lastLine = &scanIdx;
  assign cpuBusy  = (stQ != S_IDLE);

  always_comb begin
    st       = '0;
    nxt      = stQ;
    cntNext  = wordCnt;
    scanNext = scanIdx;
    doneNext = 1'b0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    unique case (stQ)
      S_IDLE: begin
        if (cmdFlush) begin
          scanNext = '0;
          nxt      = S_FSCAN;
        end else if (cmdInvalidate) begin
          st.clrAll = 1'b1;
        end else if (cpuReq) begin
          st.capture = 1'b1;
          nxt        = S_CHECK;
        end
      end
      S_CHECK: begin
        cntNext = '0;
        if (cfgBypass) begin
          nxt = S_SINGLE;
        end else if (hit) begin
          if (reqWe) begin
            st.cpuWrite  = 1'b1;
            st.markDirty = !cfgWriteThru;
            if (cfgWriteThru) nxt = S_SINGLE;
            else begin
              doneNext = 1'b1;
              nxt      = S_IDLE;
            end
          end else begin
            st.rspHit = 1'b1;
            doneNext  = 1'b1;
            nxt       = S_IDLE;
          end
        end else if (reqWe && cfgWriteThru) begin
          nxt = S_SINGLE;
        end else if (lineValid && lineDirty) begin
          nxt = S_WB;
        end else begin
          nxt = S_FILL;
        end
      end
      S_WB: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        st.addrSel = SEL_WB;
        if (memAck) begin
          cntNext = wordCnt + WOFF_W'(1);
          if (lastWord) nxt = S_FILL;
        end
      end
      S_FILL: begin
        memReq     = 1'b1;
        st.addrSel = SEL_FILL;
        if (memAck) begin
          st.fillWord = 1'b1;
          cntNext     = wordCnt + WOFF_W'(1);
          if (lastWord) begin
            st.setTag = 1'b1;
            nxt       = S_CHECK;
          end
        end
      end
      S_SINGLE: begin
        memReq     = 1'b1;
        memWe      = reqWe;
        st.addrSel = SEL_REQ;
        if (memAck) begin
          st.rspMem = !reqWe;
          doneNext  = 1'b1;
          nxt       = S_IDLE;
        end
      end
      S_FSCAN: begin
        st.useScan = 1'b1;
        cntNext    = '0;
        if (lineValid && lineDirty) begin
          nxt = S_FWB;
        end else if (lastLine) begin
          st.clrAll = 1'b1;
          nxt       = S_IDLE;
        end else begin
          scanNext = scanIdx + IDX_W'(1);
        end
      end
      S_FWB: begin
        st.useScan = 1'b1;
        memReq     = 1'b1;
        memWe      = 1'b1;
        st.addrSel = SEL_WB;
        if (memAck) begin
          cntNext = wordCnt + WOFF_W'(1);
          if (lastWord) begin
            if (lastLine) begin
              st.clrAll = 1'b1;
              nxt       = S_IDLE;
            end else begin
              scanNext = scanIdx + IDX_W'(1);
              nxt      = S_FSCAN;
            end
          end
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ     <= S_IDLE;
      wordCnt <= '0;
      scanIdx <= '0;
      cpuDone <= 1'b0;
    end else begin
      stQ     <= nxt;
      wordCnt <= cntNext;
      scanIdx <= scanNext;
      cpuDone <= doneNext;
    end
  end

  // R2: completion is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !cpuDone);

  // R11: memory traffic only while the processor is stalled
  p_mem_when_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> cpuBusy);

endmodule

// File: rtl/dmc_top.sv
module dmc_top
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 4,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgBypass,
  input  logic              cfgWriteThru,
  input  logic              cmdFlush,
  input  logic              cmdInvalidate,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuBusy,
  output logic              cpuDone,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck
);
  localparam int WOFF_W = $clog2(LINE_WORDS);

  dmc_strobe_t       st;
  logic [WOFF_W-1:0] wordCnt;
  logic [IDX_W-1:0]  scanIdx;
  logic              hit, lineValid, lineDirty, reqWe;

  dmc_ctrl #(.IDX_W(IDX_W), .LINE_WORDS(LINE_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgBypass(cfgBypass), .cfgWriteThru(cfgWriteThru),
    .cmdFlush(cmdFlush), .cmdInvalidate(cmdInvalidate), .cpuReq(cpuReq),
    .hit(hit), .lineValid(lineValid), .lineDirty(lineDirty), .reqWe(reqWe),
    .memAck(memAck), .st(st), .wordCnt(wordCnt), .scanIdx(scanIdx),
    .memReq(memReq), .memWe(memWe), .cpuBusy(cpuBusy), .cpuDone(cpuDone)
  );

  dmc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
                 .LINE_WORDS(LINE_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .wordCnt(wordCnt), .scanIdx(scanIdx),
    .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .memRdata(memRdata),
    .hit(hit), .lineValid(lineValid), .lineDirty(lineDirty), .reqWe(reqWe),
    .cpuRdata(cpuRdata), .memAddr(memAddr), .memWdata(memWdata)
  );

  // R3: a pending memory transaction holds its request and address
  p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

endmodule

// File: tb/dmc_top_bench.sv
module dmc_top_bench;
  localparam int AW = 24;
  localparam int DW = 32;

  typedef struct {
    logic        isRead;
    logic [31:0] exp;
    string       req;
  } item_t;

  typedef struct {
    logic        we;
    logic [23:0] addr;
    logic [31:0] data;
  } memop_t;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgBypass = 0, cfgWriteThru = 0, cmdFlush = 0, cmdInvalidate = 0;
  logic cpuReq = 0, cpuWe = 0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0, cpuRdata, memWdata;
  logic [DW-1:0] memRdata = '0;
  logic cpuBusy, cpuDone, memReq, memWe;
  logic memAck = 1'b0;
  logic [AW-1:0] memAddr;

  int checks = 0, errors = 0, cyc = 0, doneCyc = 0, lastLat = 0;
  int memRd = 0, memWr = 0;
  item_t  sb[$];
  memop_t memLog[$];
  logic [31:0] memW [logic [23:0]];
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dmc_top u_dmc_top (
    .clk(clk), .rstN(rstN), .cfgBypass(cfgBypass), .cfgWriteThru(cfgWriteThru),
    .cmdFlush(cmdFlush), .cmdInvalidate(cmdInvalidate), .cpuReq(cpuReq),
    .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .cpuBusy(cpuBusy), .cpuDone(cpuDone), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck)
  );

  function automatic logic [31:0] patt(logic [23:0] a);
    return {8'hC3, a};
  endfunction

  function automatic logic [31:0] memRead(logic [23:0] a);
    return memW.exists(a) ? memW[a] : patt(a);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Memory model: acknowledges each transaction after two cycles
  initial begin : mem_model
    int waitCnt = 0;
    forever begin
      @(negedge clk);
      if (memAck) begin
        memAck  = 1'b0;
        waitCnt = 0;
      end else if (memReq) begin
        if (waitCnt == 1) begin
          if (memWe) begin
            memW[memAddr] = memWdata;
            memWr++;
          end else begin
            memRdata = memRead(memAddr);
            memRd++;
          end
          memLog.push_back('{memWe, memAddr, memWe ? memWdata : memRdata});
          memAck = 1'b1;
        end else waitCnt++;
      end
    end
  end

  // Monitor: pops the scoreboard on each completion
  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (cpuDone) begin
        doneCyc = cyc;
        if (sb.size() == 0) chk(0, "R2", "unexpected done", 0, 0);
        else begin
          it = sb.pop_front();
          if (it.isRead) chk(cpuRdata === it.exp, it.req, "read data", cpuRdata, it.exp);
        end
      end
    end
  end

  // Driver: pushes the expectation and issues one access
  task automatic access(bit we, logic [23:0] addr, logic [31:0] data, logic [31:0] exp, string req);
    int startCyc;
    @(negedge clk);
    while (cpuBusy) @(negedge clk);
    sb.push_back('{!we, exp, req});
    memLog.delete();
    memRd = 0; memWr = 0;
    cpuReq = 1; cpuWe = we; cpuAddr = addr; cpuWdata = data;
    startCyc = cyc;
    @(negedge clk);
    cpuReq = 0;
    while (sb.size() != 0) @(negedge clk);
    lastLat = doneCyc - startCyc;
  endtask

  task automatic command(bit fl, bit inv);
    @(negedge clk);
    while (cpuBusy) @(negedge clk);
    memLog.delete();
    memRd = 0; memWr = 0;
    cmdFlush = fl; cmdInvalidate = inv;
    @(negedge clk);
    cmdFlush = 0; cmdInvalidate = 0;
    while (cpuBusy) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(cpuBusy === 0, "R1", "busy", cpuBusy, 0);
    chk(cpuDone === 0, "R1", "done", cpuDone, 0);
    chk(memReq === 0, "R1", "memReq", memReq, 0);

    // R1 R3: first read misses, block fetched in ascending order
    access(0, 24'h000108, 0, patt(24'h000108), "R3");
    chk(memRd == 4 && memWr == 0, "R3", "fill reads", memRd, 4);
    for (int i = 0; i < 4; i++)
      chk(memLog[i].we == 0 && memLog[i].addr == 24'h000100 + 4 * i, "R3", "fill order",
          memLog[i].addr, 24'h000100 + 4 * i);
    chk(lastLat > 2, "R1", "miss latency", lastLat, 3);

    // R2: read hit
    access(0, 24'h00010C, 0, patt(24'h00010C), "R2");
    chk(lastLat == 2, "R2", "hit latency", lastLat, 2);
    chk(memRd + memWr == 0, "R2", "hit traffic", memRd + memWr, 0);

    // R4: write-back write hit stays in cache
    access(1, 24'h000104, 32'hDEAD0001, 0, "R4");
    chk(memRd + memWr == 0, "R4", "wb write traffic", memRd + memWr, 0);
    access(0, 24'h000104, 0, 32'hDEAD0001, "R4");
    chk(lastLat == 2, "R4", "read back hit", lastLat, 2);

    // R5 R12: conflicting tag evicts dirty line
    access(0, 24'h000200, 0, patt(24'h000200), "R12");
    chk(memWr == 4 && memRd == 4, "R5", "dirty evict traffic", memWr, 4);
    for (int i = 0; i < 4; i++)
      chk(memLog[i].we == 1 && memLog[i].addr == 24'h000100 + 4 * i, "R5", "victim address",
          memLog[i].addr, 24'h000100 + 4 * i);
    chk(memRead(24'h000104) == 32'hDEAD0001, "R5", "victim data", memRead(24'h000104), 32'hDEAD0001);
    access(0, 24'h000104, 0, 32'hDEAD0001, "R12");
    chk(memWr == 0 && memRd == 4, "R5", "clean evict writes", memWr, 0);

    // R6: write-through hit writes one word and updates cache
    cfgWriteThru = 1;
    access(1, 24'h000100, 32'hBEEF0002, 0, "R6");
    chk(memWr == 1 && memRd == 0, "R6", "wt write count", memWr, 1);
    chk(memRead(24'h000100) == 32'hBEEF0002, "R6", "wt memory", memRead(24'h000100), 32'hBEEF0002);
    access(0, 24'h000100, 0, 32'hBEEF0002, "R6");
    chk(lastLat == 2 && memRd == 0, "R6", "cache updated hit", lastLat, 2);

    // R7: write-through write miss does not allocate
    access(1, 24'h000310, 32'hCAFE0003, 0, "R7");
    chk(memWr == 1 && memRd == 0, "R7", "no allocate", memRd, 0);
    access(0, 24'h000310, 0, 32'hCAFE0003, "R7");
    chk(memRd == 4, "R7", "later read misses", memRd, 4);

    // R8: bypass goes to memory and leaves lines untouched
    cfgWriteThru = 0;
    cfgBypass = 1;
    access(1, 24'h000108, 32'h11110004, 0, "R8");
    chk(memWr == 1 && memRd == 0, "R8", "bypass write", memWr, 1);
    access(0, 24'h00010C, 0, patt(24'h00010C), "R8");
    chk(memRd == 1 && memWr == 0, "R8", "bypass read", memRd, 1);
    cfgBypass = 0;
    access(0, 24'h000108, 0, patt(24'h000108), "R8");
    chk(memRd == 0 && lastLat == 2, "R8", "line unchanged", memRd, 0);

    // R9: invalidate discards dirty data
    access(1, 24'h000104, 32'h22220005, 0, "R9");
    command(0, 1);
    chk(memWr == 0, "R9", "no write-back", memWr, 0);
    access(0, 24'h000104, 0, 32'hDEAD0001, "R9");
    chk(memRd == 4, "R9", "line invalid", memRd, 4);

    // R10: flush writes dirty lines only, then invalidates
    access(1, 24'h000104, 32'h33330006, 0, "R10");
    access(1, 24'h000420, 32'h44440007, 0, "R10");
    chk(memRd == 4 && memWr == 0, "R10", "wb write allocate", memRd, 4);
    command(1, 0);
    chk(memWr == 8 && memRd == 0, "R10", "flush writes", memWr, 8);
    chk(memRead(24'h000104) == 32'h33330006, "R10", "flushed word", memRead(24'h000104), 32'h33330006);
    chk(memRead(24'h000420) == 32'h44440007, "R10", "flushed word", memRead(24'h000420), 32'h44440007);
    access(0, 24'h000310, 0, 32'hCAFE0003, "R10");
    chk(memRd == 4, "R10", "clean line invalidated", memRd, 4);

    // R11: flush wins over invalidate
    access(1, 24'h000104, 32'h55550008, 0, "R11");
    command(1, 1);
    chk(memWr == 4, "R11", "flush priority", memWr, 4);
    chk(memRead(24'h000104) == 32'h55550008, "R11", "saved data", memRead(24'h000104), 32'h55550008);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule